// File: doc/BRIEF.md
# Gray-Coded Pointer Counter

This block is a parameterised up-counter meant to drive a pointer that is handed across a clock-domain boundary. Inside, a plain binary counter advances by one whenever the increment enable is high. A second register, one flip-flop per bit, holds the Gray-coded form of the same count.

The Gray register takes its value from the binary counter's next-state value, not from the counter's registered output. Both registers therefore update on the same clock edge. The Gray output never lags the binary output by a cycle, and a single enable steers both registers.

A synchronous active-high reset clears both registers. The width is a parameter (default 9, at least 2). The receiving-side synchroniser, any decrement and any parallel load belong to the surrounding logic.

Top module: `gray_ptr_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `binCount` and `grayCount` are both zero after that edge.
- R2: When `rst` is low and `incEn` is high at a rising edge, `binCount` becomes the previous value plus one, modulo 2^WIDTH.
- R3: When `rst` and `incEn` are both low at a rising edge, `binCount` and `grayCount` keep their values, for any number of consecutive cycles.
- R4: The most significant bit of `grayCount` equals the most significant bit of `binCount` in every cycle.
- R5: For every bit position i below WIDTH-1, `grayCount[i]` equals `binCount[i] XOR binCount[i+1]` in the same cycle. The Gray value decoded back to binary equals `binCount`, with no cycle of lag.
- R6: Every increment changes exactly one bit of `grayCount`. This includes the wrap from all ones to zero, where only the most significant Gray bit falls.
- R7: Reset takes priority over the enable: with `rst` and `incEn` both high, both outputs are zero after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| incEn | input | 1 | Advance the count by one at the next edge |
| binCount | output | WIDTH | Registered binary count |
| grayCount | output | WIDTH | Registered Gray-coded count, aligned with `binCount` |

## Verification
The bench targets the wrap from all ones to zero. A counter that derives its Gray bits from a mis-sized sum, or that drops the top-bit rule, shows several bits toggling there or a non-zero value after the wrap. It compares the Gray and binary outputs in every cycle. A Gray register fed from the registered binary output instead of its next state trails by one cycle, and this comparison catches that lag at once. Long stretches with the enable low, and resets asserted together with the enable, expose a Gray register that keeps moving while the binary one is frozen, and an enable that wins over reset.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;

  // Strobes sent from the control decode to the counting datapath.
  typedef struct packed {
    logic clear;    // force both registers to zero
    logic advance;  // step the binary count by one
  } cntStrobe_t;

endpackage

// File: rtl/gcnt_ctrl.sv
module gcnt_ctrl
  import gcnt_pkg::*;
(
  input  logic       rst,
  input  logic       incEn,
  output cntStrobe_t strobe
);

  // Reset wins over the enable; the datapath never sees both strobes at once.
  always_comb begin
    strobe.clear   = rst;
    strobe.advance = incEn && !rst;
  end

endmodule

// File: rtl/gcnt_datapath.sv
module gcnt_datapath
  import gcnt_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  cntStrobe_t       strobe,
  output logic [WIDTH-1:0] binQ,
  output logic [WIDTH-1:0] grayQ
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] binNext;
  logic [WIDTH-1:0] grayNext;

  // Binary next state: a plain adder, left to map onto a carry chain.
  always_comb begin
    if (strobe.clear)        binNext = '0;
    else if (strobe.advance) binNext = binQ + 1'b1;
    else                     binNext = binQ;
  end

  // The Gray register takes its value from the binary next state, so both
  // registers move on the same edge.
  generate
    for (genvar i = 0; i < TOP; i++) begin : g_grayBit
      assign grayNext[i] = binNext[i] ^ binNext[i+1];
    end
  endgenerate
  assign grayNext[TOP] = binNext[TOP];

  always_ff @(posedge clk) begin
    binQ  <= binNext;
    grayQ <= grayNext;
  end

  // Binary register steps by one on an advance strobe.
  assert_bin_step_R2: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.advance |=> binQ == WIDTH'($past(binQ) + 1'b1));

  // With no strobe, both registers stay put.
  assert_hold_R3: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.advance |=> ($stable(binQ) && $stable(grayQ)));

  // Top bits of the two registers agree.
  assert_msb_match_R4: assert property (@(posedge clk) disable iff (strobe.clear)
    grayQ[TOP] == binQ[TOP]);

  // One Gray bit toggles per step, wrap included.
  assert_single_toggle_R6: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.advance |=> $countones(grayQ ^ $past(grayQ)) == 1);

endmodule

// File: rtl/gray_ptr_counter.sv
module gray_ptr_counter
  import gcnt_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             incEn,
  output logic [WIDTH-1:0] binCount,
  output logic [WIDTH-1:0] grayCount
);

  cntStrobe_t strobe;

  gcnt_ctrl i_ctrl (
    .rst    (rst),
    .incEn  (incEn),
    .strobe (strobe)
  );

  gcnt_datapath #(.WIDTH(WIDTH)) i_datapath (
    .clk    (clk),
    .strobe (strobe),
    .binQ   (binCount),
    .grayQ  (grayCount)
  );

  // Reset clears both outputs on the next edge.
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (binCount == '0 && grayCount == '0));

  // Reset beats a simultaneous enable.
  assert_reset_priority_R7: assert property (@(posedge clk)
    (rst && incEn) |=> binCount == '0);

endmodule

// File: tb/test_gray_ptr_counter.sv
`timescale 1ns/1ps
module test_gray_ptr_counter;

  localparam int W    = 9;
  localparam int SPAN = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         incEn = 1'b0;
  logic [W-1:0] binCount;
  logic [W-1:0] grayCount;

  int errCount = 0;
  int chkCount = 0;
  logic [W-1:0] expBin = '0;

  always #2.5 clk = ~clk;

  gray_ptr_counter #(.WIDTH(W)) i_gray_ptr_counter (
    .clk       (clk),
    .rst       (rst),
    .incEn     (incEn),
    .binCount  (binCount),
    .grayCount (grayCount)
  );

  function automatic logic [W-1:0] toGray(logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [W-1:0] fromGray(logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic int popCount(logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += v[i];
    return n;
  endfunction

  task automatic check(string req, int act, int exp);
    chkCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // One clock: drive at a falling edge, check at the next falling edge.
  task automatic cycle(bit r, bit e);
    logic [W-1:0] prevGray;
    prevGray = grayCount;
    rst   = r;
    incEn = e;
    @(negedge clk);
    if (r) expBin = '0;
    else if (e) expBin = expBin + 1'b1;
    if (r && e)      check("R7 reset beats enable", int'(binCount), int'(expBin));
    else if (r)      check("R1 reset clears count", int'(binCount), int'(expBin));
    else if (e)      check("R2 binary step", int'(binCount), int'(expBin));
    else             check("R3 binary hold", int'(binCount), int'(expBin));
    check("R5 gray matches binary", int'(grayCount), int'(toGray(expBin)));
    check("R5 gray decodes to binary", int'(fromGray(grayCount)), int'(binCount));
    check("R4 msb agree", int'(grayCount[W-1]), int'(binCount[W-1]));
    if (!r && e)      check("R6 single bit toggle", popCount(grayCount ^ prevGray), 1);
    else if (!r)      check("R3 gray hold", int'(grayCount), int'(prevGray));
  endtask

  initial begin
    #1000000;
    errCount++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCount, chkCount + 1);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20010620);
    rst = 1'b1; incEn = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset bin zero", int'(binCount), 0);
    check("R1 reset gray zero", int'(grayCount), 0);

    // R6: two full wraps, then step onto the wrap once more explicitly
    for (int k = 0; k < 2 * SPAN + 4; k++) cycle(1'b0, 1'b1);
    while (expBin != '1) cycle(1'b0, 1'b1);
    check("R6 all ones before wrap", int'(grayCount), int'(toGray('1)));
    cycle(1'b0, 1'b1);
    check("R6 wrap gray zero", int'(grayCount), 0);

    // R3: long hold mid-count
    for (int k = 0; k < 37; k++) cycle(1'b0, 1'b1);
    for (int k = 0; k < 25; k++) cycle(1'b0, 1'b0);

    // R7: reset with enable high
    cycle(1'b1, 1'b1);
    cycle(1'b0, 1'b1);

    // Random mix of enable, holds and occasional resets
    for (int k = 0; k < 3000; k++) begin
      bit r = ($urandom % 97) == 0;
      bit e = ($urandom % 4) != 0;
      cycle(r, e);
    end

    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

endmodule